// File: doc/BRIEF.md
# Boot ROM Address Decoder with A20 Wrap Control

This block sits between a processor's 32-bit physical address bus and two memory targets: a small boot ROM and main RAM. Each request is decoded in one clock. The selects and the target address appear in registers one cycle after the request. The ROM answers in two places. The first is a window at the top of the address space, where the decoded upper lines are all ones. The second is an alias window at the end of the first MiB. Both windows give the same ROM-relative address, which is the low address bits. Every other address goes to RAM.

Two pieces of state change the address before it is decoded. An A20 mask register clears bit 20 so that address sums past 1 MiB wrap as they would on a part with twenty address lines. The mask is enabled out of reset. A boot-phase state machine forces address lines 31 to 20 high on instruction fetches until software makes its first far control transfer. This lets the first fetches reach the top-of-memory ROM while the offset is still 16 bits wide.

The boot-phase machine has two states. `PH_BOOT` is entered on reset. `PH_RUN` is entered from `PH_BOOT` on a `far_xfer` pulse, which is the transition `T_FAR_JUMP`. `PH_RUN` is left only by reset.

Top module: `boot_rom_decoder`

## Requirements
- R1: After reset, both selects are low, both address outputs are zero, the boot phase is active and the A20 mask is enabled.
- R2: A request whose effective address has bits [20 +: DEC_BITS] all ones selects the ROM in the next cycle, with rom_addr equal to the low ROM_AW bits. With the mask disabled, 0xFFFFFFF0 gives rom_addr 0xFFF0.
- R3: A request whose effective address is in 0x000F0000..0x000FFFFF (for ROM_AW=16) selects the ROM, with rom_addr equal to the low 16 bits.
- R4: When the mask is enabled and the access is not boot-forced, bit 20 of the effective address is cleared. For example, 0x0010FFEF goes to RAM at 0x0000FFEF, 0x001FFFF0 reaches the alias ROM at 0xFFF0, and 0xFFFFFFF0 goes to RAM at 0xFFEFFFF0.
- R5: In the boot phase, an instruction fetch (req_is_fetch=1) has address bits 31..20 forced to ones, and the mask does not clear bit 20. Any such fetch therefore selects the ROM at the low 16 address bits. Data accesses are not forced.
- R6: A far_xfer pulse ends the boot phase from the next cycle on, and only reset starts it again. A fetch issued in the same cycle as the pulse is still forced.
- R7: A cycle with a20_wr=1 loads a20_val into the mask register (1 = mask enabled). Requests in the same cycle use the old value. Later requests use the new one, and the value holds while a20_wr=0.
- R8: A request that hits no ROM window selects RAM, with ram_addr equal to the full effective address. rom_sel and ram_sel are never high together. The output for the unselected target is zero.
- R9: A cycle with req_valid=0 gives both selects low and both addresses zero in the next cycle.
- R10: Only DEC_BITS upper lines, counted from bit 20 upward, are compared for the top window. With DEC_BITS=8 and the mask disabled, 0x0FF12340 selects the ROM at 0x2340, while with DEC_BITS=12 it goes to RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An address request is present this cycle |
| req_addr | input | ADDR_W | Physical address from the processor |
| req_is_fetch | input | 1 | The request is an instruction fetch |
| far_xfer | input | 1 | One-cycle pulse for the first far jump or far call |
| a20_wr | input | 1 | Write strobe for the A20 mask register |
| a20_val | input | 1 | Value to load; 1 enables the bit-20 mask |
| rom_sel | output | 1 | ROM selected |
| rom_addr | output | ROM_AW | ROM-relative address |
| ram_sel | output | 1 | RAM selected |
| ram_addr | output | ADDR_W | Effective address for RAM |

## Verification
Boot forcing and the A20 mask both act on bit 20 of the same fetch. The bench provokes the clash by issuing fetches while the boot phase is active and the mask is enabled out of reset. It judges the result by requiring the ROM select and the unmodified low 16 bits, not a RAM access with bit 20 cleared. The bench also places a far_xfer pulse and an A20 register write in the same cycle as a request. It then checks that the request still sees the old phase or mask and that the following request sees the new one.

// File: rtl/boot_dec_pkg.sv
package boot_dec_pkg;

    // Two-state boot phase: forced upper lines vs. normal decode
    typedef enum logic {
        PH_BOOT = 1'b0,
        PH_RUN  = 1'b1
    } boot_phase_e;

    // Decode target of one request
    typedef enum logic [1:0] {
        TGT_NONE    = 2'd0,
        TGT_ROM_TOP = 2'd1,
        TGT_ROM_LOW = 2'd2,
        TGT_RAM     = 2'd3
    } dec_target_e;

    // Bit affected by the wraparound mask; also the base of the upper lines
    localparam int WRAP_BIT = 20;

endpackage

// File: rtl/boot_phase_fsm.sv
module boot_phase_fsm
    import boot_dec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic far_xfer,
    output logic boot_active
);

    boot_phase_e phase_q;
    boot_phase_e phase_d;

    // Next-state logic
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_BOOT: if (far_xfer) phase_d = PH_RUN;   // T_FAR_JUMP
            PH_RUN:  phase_d = PH_RUN;
            default: phase_d = PH_BOOT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_BOOT;
        else        phase_q <= phase_d;
    end

    // Outputs
    always_comb begin
        unique case (phase_q)
            PH_BOOT: boot_active = 1'b1;
            PH_RUN:  boot_active = 1'b0;
            default: boot_active = 1'b1;
        endcase
    end

    // R6: once running, only reset restores the boot phase
    p_no_reentry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RUN) |=> (phase_q == PH_RUN));

    // R6: a far transfer pulse always leaves the boot phase
    p_far_ends_boot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        far_xfer |=> !boot_active);

endmodule

// File: rtl/a20_gate_reg.sv
module a20_gate_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_val,
    output logic mask_en
);

    logic mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     mask_q <= 1'b1;   // R1: wrap on by default
        else if (wr_en) mask_q <= wr_val;
    end

    assign mask_en = mask_q;

    // R7: without a write strobe the mask keeps its value
    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q));

    // R7: a write lands in the next cycle
    p_mask_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mask_q == $past(wr_val)));

endmodule

// File: rtl/addr_window_decode.sv
module addr_window_decode
    import boot_dec_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int ROM_AW   = 16,
    parameter int DEC_BITS = 12
) (
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              fetch_i,
    input  logic              boot_i,
    input  logic              mask_i,
    output logic [ADDR_W-1:0] eff_o,
    output dec_target_e       tgt_o
);

    localparam int UPPER_W = ADDR_W - WRAP_BIT;
    localparam int ALIAS_W = WRAP_BIT - ROM_AW;

    logic forced;
    logic top_hit;
    logic low_hit;

    // Effective address: boot forcing wins over the wrap mask
    always_comb begin
        forced = fetch_i & boot_i;
        eff_o  = addr_i;
        if (forced) begin
            eff_o[ADDR_W-1:WRAP_BIT] = {UPPER_W{1'b1}};
        end else if (mask_i) begin
            eff_o[WRAP_BIT] = 1'b0;
        end
    end

    // Top window: only DEC_BITS lines above bit 20 are compared
    assign top_hit = &eff_o[WRAP_BIT +: DEC_BITS];

    // Alias window at the end of the first MiB
    generate
        if (ALIAS_W > 0) begin : g_alias_sub
            assign low_hit = (eff_o[ADDR_W-1:WRAP_BIT] == '0) &&
                             (&eff_o[WRAP_BIT-1:ROM_AW]);
        end else begin : g_alias_full
            assign low_hit = (eff_o[ADDR_W-1:WRAP_BIT] == '0);
        end
    endgenerate

    always_comb begin
        if (!valid_i)     tgt_o = TGT_NONE;
        else if (top_hit) tgt_o = TGT_ROM_TOP;
        else if (low_hit) tgt_o = TGT_ROM_LOW;
        else              tgt_o = TGT_RAM;
    end

endmodule

// File: rtl/boot_rom_decoder.sv
module boot_rom_decoder
    import boot_dec_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int ROM_AW   = 16,
    parameter int DEC_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_fetch,
    input  logic              far_xfer,
    input  logic              a20_wr,
    input  logic              a20_val,
    output logic              rom_sel,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              ram_sel,
    output logic [ADDR_W-1:0] ram_addr
);

    logic              boot_active;
    logic              mask_en;
    logic [ADDR_W-1:0] eff_addr;
    dec_target_e       tgt_d;
    dec_target_e       tgt_q;
    logic [ADDR_W-1:0] eff_q;

    boot_phase_fsm u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .far_xfer    (far_xfer),
        .boot_active (boot_active)
    );

    a20_gate_reg u_a20 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (a20_wr),
        .wr_val  (a20_val),
        .mask_en (mask_en)
    );

    addr_window_decode #(
        .ADDR_W   (ADDR_W),
        .ROM_AW   (ROM_AW),
        .DEC_BITS (DEC_BITS)
    ) u_dec (
        .valid_i (req_valid),
        .addr_i  (req_addr),
        .fetch_i (req_is_fetch),
        .boot_i  (boot_active),
        .mask_i  (mask_en),
        .eff_o   (eff_addr),
        .tgt_o   (tgt_d)
    );

    // Decode result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= TGT_NONE;
            eff_q <= '0;
        end else begin
            tgt_q <= tgt_d;
            eff_q <= eff_addr;
        end
    end

    // Output drive from the registered target
    always_comb begin
        rom_sel  = 1'b0;
        rom_addr = '0;
        ram_sel  = 1'b0;
        ram_addr = '0;
        unique case (tgt_q)
            TGT_NONE: ;
            TGT_ROM_TOP, TGT_ROM_LOW: begin
                rom_sel  = 1'b1;
                rom_addr = eff_q[ROM_AW-1:0];
            end
            TGT_RAM: begin
                ram_sel  = 1'b1;
                ram_addr = eff_q;
            end
            default: ;
        endcase
    end

    // R8: never both targets
    p_sel_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_sel && ram_sel));

    // R9: an idle cycle yields idle outputs
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rom_sel && !ram_sel && rom_addr == '0 && ram_addr == '0));

    // R5: boot-phase fetches always reach the ROM at the raw offset
    p_boot_fetch_rom_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_fetch && boot_active) |=>
        (rom_sel && rom_addr == $past(req_addr[ROM_AW-1:0])));

    // R4: a masked, unforced access never carries bit 20 to RAM
    p_wrap_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mask_en && !(req_is_fetch && boot_active)) |=>
        !ram_addr[WRAP_BIT]);

    // R3: alias window addresses hit the ROM
    p_alias_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[ADDR_W-1:WRAP_BIT] == '0 &&
         (&req_addr[WRAP_BIT-1:ROM_AW])) |=> rom_sel);

    // R2: top window hits with the mask off
    p_top_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mask_en && (&req_addr[WRAP_BIT +: DEC_BITS])) |=>
        (rom_sel && rom_addr == $past(req_addr[ROM_AW-1:0])));

endmodule

// File: tb/sim_boot_rom_decoder.sv
module sim_boot_rom_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_is_fetch = 1'b0;
    logic        far_xfer = 1'b0;
    logic        a20_wr = 1'b0;
    logic        a20_val = 1'b0;
    logic        rom_sel, ram_sel, p_rom_sel, p_ram_sel;
    logic [15:0] rom_addr, p_rom_addr;
    logic [31:0] ram_addr, p_ram_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    boot_rom_decoder u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_is_fetch(req_is_fetch), .far_xfer(far_xfer), .a20_wr(a20_wr),
        .a20_val(a20_val), .rom_sel(rom_sel), .rom_addr(rom_addr),
        .ram_sel(ram_sel), .ram_addr(ram_addr)
    );

    // Partial upper decode variant
    boot_rom_decoder #(.DEC_BITS(8)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_is_fetch(req_is_fetch), .far_xfer(far_xfer), .a20_wr(a20_wr),
        .a20_val(a20_val), .rom_sel(p_rom_sel), .rom_addr(p_rom_addr),
        .ram_sel(p_ram_sel), .ram_addr(p_ram_addr)
    );

    // Table: run phase, mask enabled
    localparam int N = 8;
    localparam logic [31:0] T_ADDR [N] = '{32'h000F0000, 32'h000FFFFF, 32'h000EFFFF,
        32'h0010FFEF, 32'h001FFFF0, 32'hFFFFFFF0, 32'h12345678, 32'h00001234};
    localparam bit T_FETCH [N] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam bit T_ROM [N]   = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
    localparam logic [31:0] T_EXP [N] = '{32'h00000000, 32'h0000FFFF, 32'h000EFFFF,
        32'h0000FFEF, 32'h0000FFF0, 32'hFFEFFFF0, 32'h12245678, 32'h00001234};
    localparam string T_TAG [N] = '{"R3", "R3", "R8", "R4", "R4", "R4", "R4", "R6"};

    task automatic chk(string tag, bit e_rom, bit e_ram, logic [31:0] e_addr);
        logic [31:0] got;
        got = rom_sel ? {16'h0, rom_addr} : ram_addr;
        n_chk++;
        if (rom_sel !== e_rom || ram_sel !== e_ram ||
            (e_rom && rom_addr !== e_addr[15:0]) || (!e_rom && ram_addr !== e_addr) ||
            (e_rom && ram_addr !== 32'h0) || (!e_rom && rom_addr !== 16'h0)) begin
            n_fail++;
            $display("FAIL %s: rom=%0b ram=%0b addr=%h expected rom=%0b ram=%0b addr=%h",
                     tag, rom_sel, ram_sel, got, e_rom, e_ram, e_addr);
        end
    endtask

    // Drive one request; outputs are checked one cycle later
    task automatic req(logic [31:0] a, bit f, bit far, bit wr, bit v);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_is_fetch = f;
        far_xfer = far; a20_wr = wr; a20_val = v;
        @(negedge clk);
        req_valid = 1'b0; req_addr = '0; req_is_fetch = 1'b0;
        far_xfer = 1'b0; a20_wr = 1'b0; a20_val = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R1", 1'b0, 1'b0, 32'h0);
        // R5 with R1: boot active and mask on; forcing beats the mask
        req(32'h00001234, 1'b1, 1'b0, 1'b0, 1'b0); chk("R5", 1'b1, 1'b0, 32'h1234);
        req(32'h0010FFF0, 1'b1, 1'b0, 1'b0, 1'b0); chk("R5", 1'b1, 1'b0, 32'hFFF0);
        // R5: data not forced; R1 mask default on
        req(32'h00101234, 1'b0, 1'b0, 1'b0, 1'b0); chk("R1", 1'b0, 1'b1, 32'h00001234);
        // R6: fetch alongside far pulse is still forced, next is not
        req(32'h00002000, 1'b1, 1'b1, 1'b0, 1'b0); chk("R6", 1'b1, 1'b0, 32'h2000);
        req(32'h00002000, 1'b1, 1'b0, 1'b0, 1'b0); chk("R6", 1'b0, 1'b1, 32'h2000);

        for (int i = 0; i < N; i++) begin
            req(T_ADDR[i], T_FETCH[i], 1'b0, 1'b0, 1'b0);
            chk(T_TAG[i], T_ROM[i], !T_ROM[i], T_EXP[i]);
        end

        // R7: write mask off; same-cycle request uses old value
        req(32'h0010FFEF, 1'b0, 1'b0, 1'b1, 1'b0); chk("R7", 1'b0, 1'b1, 32'h0000FFEF);
        req(32'h0010FFEF, 1'b0, 1'b0, 1'b0, 1'b0); chk("R7", 1'b0, 1'b1, 32'h0010FFEF);
        req(32'hFFFFFFF0, 1'b0, 1'b0, 1'b0, 1'b0); chk("R2", 1'b1, 1'b0, 32'hFFF0);
        req(32'hFFF01234, 1'b1, 1'b0, 1'b0, 1'b0); chk("R2", 1'b1, 1'b0, 32'h1234);
        req(32'hFFE01234, 1'b0, 1'b0, 1'b0, 1'b0); chk("R8", 1'b0, 1'b1, 32'hFFE01234);
        // R10: partial decode
        req(32'h0FF12340, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10", 1'b0, 1'b1, 32'h0FF12340);
        n_chk++;
        if (p_rom_sel !== 1'b1 || p_ram_sel !== 1'b0 || p_rom_addr !== 16'h2340) begin
            n_fail++;
            $display("FAIL R10: rom=%0b addr=%h expected rom=1 addr=2340", p_rom_sel, p_rom_addr);
        end
        // R9: idle cycle
        @(negedge clk); chk("R9", 1'b0, 1'b0, 32'h0);
        // R7: mask back on
        req(32'h00000000, 1'b0, 1'b0, 1'b1, 1'b1); chk("R8", 1'b0, 1'b1, 32'h0);
        req(32'h0010FFEF, 1'b0, 1'b0, 1'b0, 1'b0); chk("R7", 1'b0, 1'b1, 32'h0000FFEF);

        // R1: reset restores boot phase and mask
        do_reset();
        chk("R1", 1'b0, 1'b0, 32'h0);
        req(32'h00000000, 1'b1, 1'b0, 1'b0, 1'b0); chk("R1", 1'b1, 1'b0, 32'h0);
        req(32'h0010FFEF, 1'b0, 1'b0, 1'b0, 1'b0); chk("R1", 1'b0, 1'b1, 32'h0000FFEF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule